// File: doc/BRIEF.md
# SMBus Packet Timeout Monitor

This block sits beside the target-side logic of an SMBus or PMBus interface and limits how long one whole packet may take. It watches the clock and data lines. Each line passes through its own synchronizer, and the block then finds START and STOP conditions. A millisecond timer starts at the START that opens a packet. Repeated STARTs, address bytes, acknowledge bits and data bytes do not stop or restart it. Only a STOP ends the timed window.

If the limit is reached before the STOP, the block raises a one-cycle timeout pulse. It also raises two levels: one tells the target to float SDA and SCL, and the other tells the target to drop everything it has received in the current packet. The release level clears at the next STOP or when the bus is seen idle. The discard level clears when the next packet opens. The short limit applies by default. A configuration input selects the long limit. Target logic that has decoded a fault-log block read can raise a second input, which forces the long limit whatever the configuration says.

The millisecond tick comes from a prescaler on the system clock. All limits, the prescaler ratio, the idle time and the synchronizer depth are parameters. Elaboration rejects a short limit below the minimum or a long limit below the short one.

Top module: `pkt_timeout_mon`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `timeout_o`, `bus_release_o` and `discard_o` are all low.
- R2: A START (SDA falling while SCL is high) on an idle monitor opens a packet. With both limit inputs low, `timeout_o` rises on the (SHORT_MS*CLK_PER_MS+4)th rising clock edge, counting from the first edge that samples the falling SDA.
- R3: A repeated START inside an open packet neither restarts nor stops the timer. The expiry cycle stays the one fixed by the first START.
- R4: A STOP (SDA rising while SCL is high) before the limit closes the packet, and no timeout follows.
- R5: With `long_cfg_i` high, the limit is LONG_MS milliseconds, so `timeout_o` rises on edge LONG_MS*CLK_PER_MS+4.
- R6: With `fault_log_rd_i` high, the limit is LONG_MS milliseconds even while `long_cfg_i` is low.
- R7: On expiry, `timeout_o` is high for exactly one cycle, and `bus_release_o` and `discard_o` rise in that same cycle.
- R8: A STOP clears `bus_release_o`. `discard_o` stays high until the START of the next packet, which clears it.
- R9: After a timeout, `bus_release_o` also clears once both synchronized lines have stayed high for IDLE_CLKS consecutive clocks.
- R10: SDA changes while SCL is low are data bits, not conditions. They neither open nor close a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| long_cfg_i | input | 1 | Selects the long packet limit |
| fault_log_rd_i | input | 1 | Current packet is a fault-log block read; forces the long limit |
| timeout_o | output | 1 | One-cycle pulse on packet expiry |
| bus_release_o | output | 1 | Target must float SDA and SCL while high |
| discard_o | output | 1 | Target must ignore the data of the expired packet while high |

## Verification
A pad edge takes two synchronizer edges and one condition-detect edge before the timer reacts. `timeout_o` therefore appears on edge L*CLK_PER_MS+4, counting from the first edge that samples the edge. Release and discard rise on that same edge. A STOP clears release three edges after it is first sampled. The bench keeps a behavioural model that is stepped on every rising edge and compares all three outputs with it on each falling edge. This way, every one of these latencies is checked in the exact cycle it is due. On top of that, the bench records the cycle number of each START and compares the cycle in which each timeout is seen against the limit the requirement gives.

// File: rtl/pkt_tmo_pkg.sv
package pkt_tmo_pkg;

   // bus events produced by the condition detector, one cycle each
   typedef struct packed {
      logic start;   // SDA fell while SCL high
      logic stop;    // SDA rose while SCL high
      logic idle;    // both lines high for the idle window (single pulse)
   } bus_evt_t;

   function automatic int unsigned max_u(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ptm_sync.sv
module ptm_sync #(
   parameter int unsigned WIDTH   = 2,
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ptm_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_line
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= {STAGES{RST_VAL}};
         else        chain_q <= {chain_q[STAGES-2:0], d_i[i]};
      end
      assign q_o[i] = chain_q[STAGES-1];
   end

endmodule

// File: rtl/ptm_bus_cond.sv
module ptm_bus_cond
   import pkt_tmo_pkg::*;
#(
   parameter int unsigned IDLE_CLKS = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_s,
   input  logic     sda_s,
   output bus_evt_t evt_o
);

   logic sda_d;
   logic both_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sda_d <= 1'b1;
      else        sda_d <= sda_s;
   end

   assign both_hi     = scl_s & sda_s;
   assign evt_o.start = scl_s &  sda_d & ~sda_s;
   assign evt_o.stop  = scl_s & ~sda_d &  sda_s;

   if (IDLE_CLKS == 0) begin : g_no_idle
      assign evt_o.idle = 1'b0;
   end else begin : g_idle
      localparam int unsigned IW = max_u($clog2(IDLE_CLKS + 1), 1);
      localparam logic [IW-1:0] CNT_END  = IW'(IDLE_CLKS);
      localparam logic [IW-1:0] CNT_LAST = IW'(IDLE_CLKS - 1);
      logic [IW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             cnt_q <= '0;
         else if (!both_hi)      cnt_q <= '0;
         else if (cnt_q != CNT_END) cnt_q <= cnt_q + 1'b1;
      end

      // fires once per idle stretch: the counter parks at CNT_END
      assign evt_o.idle = both_hi && (cnt_q == CNT_LAST);
   end

endmodule

// File: rtl/ptm_prescaler.sv
module ptm_prescaler #(
   parameter int unsigned DIV = 125000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic en_i,
   output logic tick_o
);

   localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("ptm_prescaler: DIV must be at least 2");
   end

   logic [PW-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             pre_q <= '0;
      else if (clr_i)         pre_q <= '0;
      else if (en_i) begin
         if (pre_q == LAST)   pre_q <= '0;
         else                 pre_q <= pre_q + 1'b1;
      end
   end

   assign tick_o = en_i && (pre_q == LAST);

endmodule

// File: rtl/pkt_timeout_mon.sv
module pkt_timeout_mon
   import pkt_tmo_pkg::*;
#(
   parameter int unsigned CLK_PER_MS  = 125000,
   parameter int unsigned SHORT_MS    = 30,
   parameter int unsigned LONG_MS     = 255,
   parameter int unsigned MIN_MS      = 25,
   parameter int unsigned IDLE_CLKS   = 6250,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   input  logic long_cfg_i,
   input  logic fault_log_rd_i,
   output logic timeout_o,
   output logic bus_release_o,
   output logic discard_o
);

   localparam int unsigned MSW = max_u($clog2(LONG_MS + 1), 1);
   localparam logic [MSW-1:0] SHORT_L = MSW'(SHORT_MS);
   localparam logic [MSW-1:0] LONG_L  = MSW'(LONG_MS);

   if (SHORT_MS < MIN_MS) begin : g_bad_short
      $error("pkt_timeout_mon: SHORT_MS below MIN_MS");
   end
   if (LONG_MS < SHORT_MS) begin : g_bad_long
      $error("pkt_timeout_mon: LONG_MS below SHORT_MS");
   end

   logic [1:0] sync_q;
   logic       scl_s, sda_s;
   bus_evt_t   evt;
   logic       start_w, stop_w, idle_w;
   logic       active_q;
   logic [MSW-1:0] ms_q;
   logic [MSW-1:0] lim_ms;
   logic       start_new, expire, set_w, tick;

   ptm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({scl_i, sda_i}),
      .q_o   (sync_q)
   );
   assign scl_s = sync_q[1];
   assign sda_s = sync_q[0];

   ptm_bus_cond #(.IDLE_CLKS(IDLE_CLKS)) u_cond (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_s (scl_s),
      .sda_s (sda_s),
      .evt_o (evt)
   );
   assign start_w = evt.start;
   assign stop_w  = evt.stop;
   assign idle_w  = evt.idle;

   ptm_prescaler #(.DIV(CLK_PER_MS)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (start_new),
      .en_i   (active_q),
      .tick_o (tick)
   );

   assign lim_ms    = (long_cfg_i || fault_log_rd_i) ? LONG_L : SHORT_L;
   assign start_new = start_w && !active_q;
   assign expire    = active_q && (ms_q >= lim_ms);
   assign set_w     = expire && !stop_w;

   // packet window: only the opening START and a STOP move it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         ms_q     <= '0;
      end else if (start_new) begin
         active_q <= 1'b1;
         ms_q     <= '0;
      end else if (stop_w || expire) begin
         active_q <= 1'b0;
      end else if (tick) begin
         ms_q     <= ms_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timeout_o     <= 1'b0;
         bus_release_o <= 1'b0;
         discard_o     <= 1'b0;
      end else begin
         timeout_o <= set_w;

         if (set_w)                bus_release_o <= 1'b1;
         else if (stop_w || idle_w) bus_release_o <= 1'b0;

         if (start_new)            discard_o <= 1'b0;
         else if (set_w)           discard_o <= 1'b1;
      end
   end

endmodule

// File: rtl/pkt_timeout_mon_chk.sv
module pkt_timeout_mon_chk (
   input logic clk,
   input logic rst_n,
   input logic timeout_o,
   input logic bus_release_o,
   input logic discard_o,
   input logic start_w,
   input logic stop_w,
   input logic active_q
);

   p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |=> !timeout_o);

   p_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> (bus_release_o && discard_o));

   p_rel_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_release_o) |-> timeout_o);

   p_stop_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_w |=> !bus_release_o);

   p_disc_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_w && !active_q) |=> !discard_o);

   p_to_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_o) |-> $past(active_q));

endmodule

bind pkt_timeout_mon pkt_timeout_mon_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .timeout_o     (timeout_o),
   .bus_release_o (bus_release_o),
   .discard_o     (discard_o),
   .start_w       (start_w),
   .stop_w        (stop_w),
   .active_q      (active_q)
);

// File: tb/pkt_timeout_mon_tb.sv
`timescale 1ns/1ps
module pkt_timeout_mon_tb;

   localparam int CPT   = 4;
   localparam int SHORT = 30;
   localparam int LONG  = 255;
   localparam int IDLE  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, sda = 1'b1, long_cfg = 1'b0, flt = 1'b0;
   logic timeout_o, bus_release_o, discard_o;

   int checks = 0, errors = 0, cyc = 0, to_cnt = 0, c0 = 0;
   bit done = 0;

   always #4 clk = ~clk;

   pkt_timeout_mon #(.CLK_PER_MS(CPT), .SHORT_MS(SHORT), .LONG_MS(LONG),
                     .MIN_MS(25), .IDLE_CLKS(IDLE), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
      .long_cfg_i(long_cfg), .fault_log_rd_i(flt),
      .timeout_o(timeout_o), .bus_release_o(bus_release_o), .discard_o(discard_o));

   // ---------------- behavioural reference model ----------------
   bit s1_scl, s1_sda, s2_scl, s2_sda, p_sda;
   bit m_act, m_to, m_rel, m_disc;
   int m_pre, m_ms, m_idle;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         {s1_scl, s1_sda, s2_scl, s2_sda, p_sda} = 5'b11111;
         m_act = 0; m_to = 0; m_rel = 0; m_disc = 0;
         m_pre = 0; m_ms = 0; m_idle = 0;
      end else begin
         bit st, sp, idl, ex, setv, both;
         int lim;
         st   = p_sda && !s2_sda && s2_scl;
         sp   = !p_sda && s2_sda && s2_scl;
         both = s2_scl && s2_sda;
         idl  = both && (m_idle == IDLE - 1);
         lim  = (long_cfg || flt) ? LONG : SHORT;
         ex   = m_act && (m_ms >= lim);
         setv = ex && !sp;
         m_to = setv;
         if (setv) m_rel = 1; else if (sp || idl) m_rel = 0;
         if (st && !m_act) m_disc = 0; else if (setv) m_disc = 1;
         if (st && !m_act) begin m_act = 1; m_pre = 0; m_ms = 0; end
         else if (sp || ex) m_act = 0;
         else if (m_act) begin
            if (m_pre == CPT - 1) begin m_pre = 0; m_ms++; end
            else m_pre++;
         end
         if (!both) m_idle = 0; else if (m_idle != IDLE) m_idle++;
         p_sda = s2_sda; s2_sda = s1_sda; s2_scl = s1_scl;
         s1_sda = sda;   s1_scl = scl;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // compare against the model on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(timeout_o == m_to, "R2 timeout vs model", timeout_o, m_to);
         check(bus_release_o == m_rel, "R9 release vs model", bus_release_o, m_rel);
         check(discard_o == m_disc, "R8 discard vs model", discard_o, m_disc);
         if (timeout_o) to_cnt++;
      end
   end

   // ---------------- bus stimulus ----------------
   task automatic drive(input bit s, input bit d, input int n);
      @(negedge clk); scl = s; sda = d;
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic bus_start();
      drive(1, 1, 4);
      @(negedge clk); sda = 0;
      @(negedge clk); c0 = cyc;
      repeat (2) @(negedge clk);
      drive(0, 0, 4);
   endtask

   task automatic bus_bit(input bit b);
      drive(0, b, 3); drive(1, b, 3); drive(0, b, 2);
   endtask

   task automatic bus_rstart();
      drive(0, 1, 3); drive(1, 1, 3); drive(1, 0, 3); drive(0, 0, 3);
   endtask

   task automatic bus_stop();
      drive(0, 0, 3); drive(1, 0, 3); drive(1, 1, 3);
   endtask

   task automatic wait_to(input int max_n, output int at);
      at = -1;
      for (int i = 0; i < max_n; i++) begin
         @(negedge clk);
         if (timeout_o) begin at = cyc; break; end
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=0", cyc);
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int at, n0;
      repeat (5) @(negedge clk);
      check(!timeout_o && !bus_release_o && !discard_o, "R1 in reset",
            {timeout_o, bus_release_o, discard_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!timeout_o && !bus_release_o && !discard_o, "R1 after reset",
            {timeout_o, bus_release_o, discard_o}, 0);

      // short limit, data toggles under SCL low, repeated START, no STOP
      bus_start();
      for (int i = 0; i < 4; i++) bus_bit(i[0]);
      bus_rstart();
      for (int i = 0; i < 3; i++) bus_bit(!i[0]);
      drive(0, 1, 2); drive(1, 1, 2);
      wait_to(400, at);
      check(at == c0 + 3 + SHORT * CPT, "R2 short expiry cycle", at, c0 + 3 + SHORT * CPT);
      check(at == c0 + 3 + SHORT * CPT, "R3 repeated START kept timer", at, c0 + 3 + SHORT * CPT);
      check(at == c0 + 3 + SHORT * CPT, "R10 SCL-low SDA edges ignored", at, c0 + 3 + SHORT * CPT);
      check(bus_release_o && discard_o, "R7 flags with pulse", {bus_release_o, discard_o}, 3);
      @(negedge clk);
      check(!timeout_o, "R7 single-cycle pulse", timeout_o, 0);
      drive(0, 1, 4);
      drive(1, 1, IDLE + 8);
      check(!bus_release_o, "R9 idle clears release", bus_release_o, 0);
      check(discard_o, "R8 discard held until START", discard_o, 1);

      // STOP before expiry
      n0 = to_cnt;
      bus_start();
      check(!discard_o, "R8 START clears discard", discard_o, 0);
      bus_bit(1); bus_bit(0);
      bus_stop();
      repeat (SHORT * CPT + 40) @(negedge clk);
      check(to_cnt == n0, "R4 no timeout after STOP", to_cnt - n0, 0);

      // long limit by configuration
      long_cfg = 1'b1;
      bus_start();
      wait_to(LONG * CPT + 40, at);
      check(at == c0 + 3 + LONG * CPT, "R5 long expiry cycle", at, c0 + 3 + LONG * CPT);
      bus_stop();
      repeat (2) @(negedge clk);
      check(!bus_release_o, "R8 STOP clears release", bus_release_o, 1'b0);
      check(discard_o, "R8 discard kept over STOP", discard_o, 1);

      // long limit forced by fault-log read
      long_cfg = 1'b0; flt = 1'b1;
      bus_start();
      wait_to(LONG * CPT + 40, at);
      check(at == c0 + 3 + LONG * CPT, "R6 fault-log long expiry", at, c0 + 3 + LONG * CPT);
      bus_stop();
      flt = 1'b0;
      repeat (10) @(negedge clk);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule